// File: doc/BRIEF.md
# Read-Disturb Aware Cache Line Store Controller

This controller sits between a cache's data request port and a line array whose cells can be flipped by the act of reading them. Each block holds one 64-byte line. For each block the controller keeps a 4-bit compression code in a separate table built from ordinary registers, which a read does not disturb. A requester that has already compressed a line hands over the block index, the code and the payload. The payload is packed into the low bytes, and its size follows from the code. Compression, decompression and tag lookup are done outside the block.

The code alone tells the controller how to treat the array. An all-zero line is never stored and never read. A line whose payload is 32 bytes or less is stored twice, once in each half of the block. Anything wider is stored once. On a read of a duplicated line, the copy in the upper half is taken and consumed, and the code drops to its single-copy form. This replaces the restore write that such a read would otherwise need. A read of a single-copy line is followed at once by a restore write of the same bytes, and the array port is held until that write is done.

Top module: `rdc_ctrl`

## Requirements
- R1: After reset every block holds code 0000, `req_ready` is high, both counters are zero, and a read of any block returns all-zero data without touching the array.
- R2: A write with code 0000 issues no array operation. A later read of that block returns zero data one cycle after acceptance, issues no array operation and issues no restore.
- R3: A write with a two-copy code stores the first N payload bytes in lanes 0..N-1 and again in lanes 32..32+N-1 in a single array write. The codes and their N are 0011→8, 0110→15, 1101→19 and 0111→22.
- R4: The first read after a two-copy write reads only lanes 32..32+N-1 and issues no restore. It returns that copy aligned to byte 0 and reports the two-copy code. It then changes the stored code as follows: 0011→0001, 0110→0010, 1101→1100, 0111→0101.
- R5: A read of a single-copy, non-zero code reads lanes 0..N-1. In the next cycle it writes the same lanes back with the bytes just read, and it leaves the code unchanged. The single-copy sizes are 0001→8, 0010→15, 0101→22, 1100→19, 0100→34, 1110→33, 1000→36 and 1111→64. The unused codes 1001, 1010 and 1011 are treated as 64-byte single copies.
- R6: Any write replaces the block's code and stored copies, whatever the block's earlier state.
- R7: `req_ready` is high only when the controller is idle. A non-zero read responds two cycles after acceptance, and a zero read responds one cycle after acceptance. A write or a restore holds `req_ready` low until its array write has been issued.
- R8: `cnt_skip` counts accepted reads of zero or two-copy codes, and `cnt_restore` counts accepted reads that issue a restore.
- R9: Response bytes at or above the code's size N are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Block (set/way) index |
| req_code | input | 4 | Compression code for a write |
| req_wdata | input | LINE_BYTES*8 | Compressed payload in the low bytes |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | LINE_BYTES*8 | Payload read, aligned to byte 0 |
| rsp_code | output | 4 | Code held by the block when the read was accepted |
| arr_en | output | 1 | Array operation |
| arr_we | output | 1 | Array write (else read) |
| arr_index | output | IDX_W | Array block index |
| arr_bmask | output | LINE_BYTES | Byte lanes touched |
| arr_wdata | output | LINE_BYTES*8 | Array write data |
| arr_rdata | input | LINE_BYTES*8 | Array read data, one cycle after a read |
| cnt_skip | output | CNT_W | Reads served without a restore |
| cnt_restore | output | CNT_W | Reads that issued a restore |

## Verification
The hardest case to reach from the ports is the one the design exists for: a duplicated line that has been read once. Its upper copy is now corrupt but still marked valid in the array. Only a wrong choice of copy on a later read, or a missing restore, would expose it. The bench's array model flips every byte it reads, the way a disturbing read would. Each two-copy block is then read three times in a row, so a controller that picks the wrong copy, skips a restore, or fails to change the code returns corrupted bytes.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_ZERO  = 4'b0000;
    localparam code_t C_REP_S = 4'b0001;
    localparam code_t C_REP_D = 4'b0011;
    localparam code_t C_W15_S = 4'b0010;
    localparam code_t C_W15_D = 4'b0110;
    localparam code_t C_W22_S = 4'b0101;
    localparam code_t C_W22_D = 4'b0111;
    localparam code_t C_W19_S = 4'b1100;
    localparam code_t C_W19_D = 4'b1101;
    localparam code_t C_W34   = 4'b0100;
    localparam code_t C_W33   = 4'b1110;
    localparam code_t C_W36   = 4'b1000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_RSP,
        ST_ZRSP
    } fsm_e;

    typedef struct packed {
        logic       zero;
        logic       dual;
        logic [6:0] nbytes;
    } decode_t;

    function automatic logic is_dual(code_t c);
        return (c == C_REP_D) || (c == C_W15_D) || (c == C_W19_D) || (c == C_W22_D);
    endfunction

    function automatic code_t to_single(code_t c);
        case (c)
            C_REP_D: return C_REP_S;
            C_W15_D: return C_W15_S;
            C_W19_D: return C_W19_S;
            C_W22_D: return C_W22_S;
            default: return c;
        endcase
    endfunction

    function automatic logic [6:0] payload_bytes(code_t c);
        case (c)
            C_ZERO:           return 7'd0;
            C_REP_S, C_REP_D: return 7'd8;
            C_W15_S, C_W15_D: return 7'd15;
            C_W19_S, C_W19_D: return 7'd19;
            C_W22_S, C_W22_D: return 7'd22;
            C_W33:            return 7'd33;
            C_W34:            return 7'd34;
            C_W36:            return 7'd36;
            default:          return 7'd64;
        endcase
    endfunction

    function automatic decode_t decode(code_t c);
        decode_t d;
        d.zero   = (c == C_ZERO);
        d.dual   = is_dual(c);
        d.nbytes = payload_bytes(c);
        return d;
    endfunction

endpackage

// File: rtl/rdc_state_table.sv
module rdc_state_table
    import rdc_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output code_t            rd_code,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  code_t            wr_code
);

    code_t codes [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BLOCKS; i++) codes[i] <= C_ZERO;
        end else if (wr_en) begin
            codes[wr_idx] <= wr_code;
        end
    end

    assign rd_code = codes[rd_idx];

    // R6: a table write is visible at the same index on the following cycle
    assert_table_update_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_idx == wr_idx) ##1 (rd_idx == $past(wr_idx)) |-> rd_code == $past(wr_code));

endmodule

// File: rtl/rdc_lane_map.sv
module rdc_lane_map #(
    parameter int LINE_BYTES = 64,
    localparam int HALF = LINE_BYTES / 2
) (
    input  logic [6:0]            nbytes,
    input  logic                  sel_lo,
    input  logic                  sel_hi,
    output logic [LINE_BYTES-1:0] mask
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        if (b >= HALF) begin : g_upper
            assign mask[b] = (sel_lo && (b < int'(nbytes))) ||
                             (sel_hi && ((b - HALF) < int'(nbytes)));
        end else begin : g_lower
            assign mask[b] = sel_lo && (b < int'(nbytes));
        end
    end

endmodule

// File: rtl/rdc_stat_ctr.sv
module rdc_stat_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_skip,
    input  logic             inc_rest,
    output logic [CNT_W-1:0] cnt_skip,
    output logic [CNT_W-1:0] cnt_restore
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_skip    <= '0;
            cnt_restore <= '0;
        end else begin
            if (inc_skip) cnt_skip    <= cnt_skip + 1'b1;
            if (inc_rest) cnt_restore <= cnt_restore + 1'b1;
        end
    end

    // R8: one read is classified exactly one way
    assert_single_class_R8: assert property (@(posedge clk) disable iff (rst)
        !(inc_skip && inc_rest));

endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
    import rdc_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int NUM_BLOCKS = 16,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(NUM_BLOCKS),
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int HALF      = LINE_BYTES / 2,
    localparam int HALF_BITS = HALF * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [IDX_W-1:0]      req_index,
    input  logic [3:0]            req_code,
    input  logic [LINE_BITS-1:0]  req_wdata,
    output logic                  rsp_valid,
    output logic [LINE_BITS-1:0]  rsp_data,
    output logic [3:0]            rsp_code,
    output logic                  arr_en,
    output logic                  arr_we,
    output logic [IDX_W-1:0]      arr_index,
    output logic [LINE_BYTES-1:0] arr_bmask,
    output logic [LINE_BITS-1:0]  arr_wdata,
    input  logic [LINE_BITS-1:0]  arr_rdata,
    output logic [CNT_W-1:0]      cnt_skip,
    output logic [CNT_W-1:0]      cnt_restore
);

    fsm_e                 fsm;
    code_t                cur_code;
    code_t                r_code;
    logic [IDX_W-1:0]     r_index;
    logic [LINE_BITS-1:0] r_wdata;
    decode_t              cur_dec;
    decode_t              r_dec;
    logic                 accept;
    logic                 rd_accept;
    logic                 tbl_we;
    code_t                tbl_wcode;
    logic                 sel_lo, sel_hi;
    logic [LINE_BYTES-1:0] lane_mask;
    logic [LINE_BYTES-1:0] keep_mask;
    logic [LINE_BITS-1:0]  sel_line;
    logic                  restoring;

    assign req_ready = (fsm == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_accept = accept && !req_write;
    assign cur_dec   = decode(cur_code);
    assign r_dec     = decode(r_code);

    // per-block code storage, immune to read disturbance
    assign tbl_we    = accept && (req_write || cur_dec.dual);
    assign tbl_wcode = req_write ? code_t'(req_code) : to_single(cur_code);

    rdc_state_table #(.NUM_BLOCKS(NUM_BLOCKS)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_index),
        .rd_code (cur_code),
        .wr_en   (tbl_we),
        .wr_idx  (req_index),
        .wr_code (tbl_wcode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm     <= ST_IDLE;
            r_code  <= C_ZERO;
            r_index <= '0;
            r_wdata <= '0;
        end else begin
            case (fsm)
                ST_IDLE: if (accept) begin
                    r_index <= req_index;
                    if (req_write) begin
                        r_code  <= req_code;
                        r_wdata <= req_wdata;
                        fsm     <= (req_code == C_ZERO) ? ST_IDLE : ST_WR;
                    end else begin
                        r_code <= cur_code;
                        fsm    <= cur_dec.zero ? ST_ZRSP : ST_RD;
                    end
                end
                ST_RD:   fsm <= ST_RSP;
                default: fsm <= ST_IDLE;
            endcase
        end
    end

    // byte lanes: writes touch both halves for duplicated data,
    // a duplicated read takes the upper copy, a single read/restore the lower lanes
    assign restoring = (fsm == ST_RSP) && !r_dec.dual;
    assign sel_lo    = (fsm == ST_WR) || (((fsm == ST_RD) || restoring) && !r_dec.dual);
    assign sel_hi    = ((fsm == ST_WR) || (fsm == ST_RD)) && r_dec.dual;

    rdc_lane_map #(.LINE_BYTES(LINE_BYTES)) u_lane_arr (
        .nbytes (r_dec.nbytes),
        .sel_lo (sel_lo),
        .sel_hi (sel_hi),
        .mask   (lane_mask)
    );

    rdc_lane_map #(.LINE_BYTES(LINE_BYTES)) u_lane_keep (
        .nbytes (r_dec.nbytes),
        .sel_lo (1'b1),
        .sel_hi (1'b0),
        .mask   (keep_mask)
    );

    assign arr_en    = (fsm == ST_WR) || (fsm == ST_RD) || restoring;
    assign arr_we    = (fsm == ST_WR) || restoring;
    assign arr_index = r_index;
    assign arr_bmask = arr_en ? lane_mask : '0;

    always_comb begin
        if (fsm == ST_WR)
            arr_wdata = r_dec.dual ? {r_wdata[HALF_BITS-1:0], r_wdata[HALF_BITS-1:0]} : r_wdata;
        else
            arr_wdata = arr_rdata;
    end

    assign sel_line = r_dec.dual ? {{HALF_BITS{1'b0}}, arr_rdata[LINE_BITS-1:HALF_BITS]} : arr_rdata;

    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++)
            rsp_data[8*b +: 8] = ((fsm == ST_RSP) && keep_mask[b]) ? sel_line[8*b +: 8] : 8'h00;
    end

    assign rsp_valid = (fsm == ST_RSP) || (fsm == ST_ZRSP);
    assign rsp_code  = r_code;

    rdc_stat_ctr #(.CNT_W(CNT_W)) u_stats (
        .clk         (clk),
        .rst         (rst),
        .inc_skip    (rd_accept && (cur_dec.zero || cur_dec.dual)),
        .inc_rest    (rd_accept && !cur_dec.zero && !cur_dec.dual),
        .cnt_skip    (cnt_skip),
        .cnt_restore (cnt_restore)
    );

    // R2: a zero-coded read leaves the array idle
    assert_zero_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_accept && cur_code == C_ZERO) |=> (!arr_en && rsp_valid));

    // R3: duplicated write carries identical halves and identical lane sets
    assert_dup_sym_R3: assert property (@(posedge clk) disable iff (rst)
        (arr_we && arr_bmask[HALF] && !arr_bmask[HALF-1]) |->
        (arr_bmask[HALF-1:0] == arr_bmask[LINE_BYTES-1:HALF] &&
         arr_wdata[HALF_BITS-1:0] == arr_wdata[LINE_BITS-1:HALF_BITS]));

    // R4: an upper-copy-only read is never followed by a restore
    assert_upper_norestore_R4: assert property (@(posedge clk) disable iff (rst)
        (arr_en && !arr_we && arr_bmask[HALF-1:0] == '0) |=> !arr_en);

    // R5: a read touching the lower lanes is followed by a write of the same lanes
    assert_restore_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (arr_en && !arr_we && arr_bmask[HALF-1:0] != '0) |=>
        (arr_en && arr_we && arr_bmask == $past(arr_bmask) && arr_index == $past(arr_index)));

    // R7: no request accepted while the array port is occupied
    assert_busy_R7: assert property (@(posedge clk) disable iff (rst)
        arr_en |-> !req_ready);

    // R7: non-zero read responds two cycles after acceptance
    assert_rsp_lat_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_accept && cur_code != C_ZERO) |=> ##1 rsp_valid);

endmodule

// File: tb/tb_rdc_ctrl.sv
`timescale 1ns/1ps
module tb_rdc_ctrl;

    localparam int LB = 64;
    localparam int LBITS = LB * 8;
    localparam int NB = 16;
    localparam int IW = 4;
    localparam int CW = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [IW-1:0]    req_index = '0;
    logic [3:0]       req_code = '0;
    logic [LBITS-1:0] req_wdata = '0;
    logic             rsp_valid;
    logic [LBITS-1:0] rsp_data;
    logic [3:0]       rsp_code;
    logic             arr_en, arr_we;
    logic [IW-1:0]    arr_index;
    logic [LB-1:0]    arr_bmask;
    logic [LBITS-1:0] arr_wdata;
    logic [LBITS-1:0] arr_rdata = '0;
    logic [CW-1:0]    cnt_skip, cnt_restore;

    int errors = 0, checks = 0;
    int rd_ops = 0, wr_ops = 0;
    int exp_skip = 0, exp_rest = 0;
    logic [LB-1:0] last_rmask = '0, last_wmask = '0;
    logic [LBITS-1:0] mem [NB];
    bit done = 0;

    always #4 clk = ~clk;

    rdc_ctrl #(.LINE_BYTES(LB), .NUM_BLOCKS(NB), .CNT_W(CW)) dut (.*);

    // array model: every read flips the bytes it senses
    always @(posedge clk) begin
        if (arr_en) begin
            if (arr_we) begin
                for (int b = 0; b < LB; b++)
                    if (arr_bmask[b]) mem[arr_index][8*b +: 8] <= arr_wdata[8*b +: 8];
                wr_ops <= wr_ops + 1;
                last_wmask <= arr_bmask;
            end else begin
                arr_rdata <= mem[arr_index];
                for (int b = 0; b < LB; b++)
                    if (arr_bmask[b]) mem[arr_index][8*b +: 8] <= mem[arr_index][8*b +: 8] ^ 8'hA5;
                rd_ops <= rd_ops + 1;
                last_rmask <= arr_bmask;
            end
        end
    end

    function automatic int bsize(logic [3:0] c);
        case (c)
            4'b0000: return 0;
            4'b0001, 4'b0011: return 8;
            4'b0010, 4'b0110: return 15;
            4'b1100, 4'b1101: return 19;
            4'b0101, 4'b0111: return 22;
            4'b1110: return 33;
            4'b0100: return 34;
            4'b1000: return 36;
            default: return 64;
        endcase
    endfunction

    function automatic logic [LB-1:0] lanes(int n, int off);
        logic [LB-1:0] m = '0;
        for (int i = 0; i < LB; i++) if (i >= off && i < off + n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [LBITS-1:0] pattern(int seed);
        logic [LBITS-1:0] p;
        for (int i = 0; i < LB; i++) p[8*i +: 8] = 8'(seed * 29 + i * 13 + 1);
        return p;
    endfunction

    function automatic logic [LBITS-1:0] trunc(logic [LBITS-1:0] p, int n);
        logic [LBITS-1:0] t = '0;
        for (int i = 0; i < LB; i++) if (i < n) t[8*i +: 8] = p[8*i +: 8];
        return t;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [LBITS-1:0] act, input logic [LBITS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [3:0] code, input logic [LBITS-1:0] p,
                            input int exp_wr, input logic [LB-1:0] exp_mask, input string rq);
        int w0;
        w0 = wr_ops;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready before write", LBITS'(req_ready), 1);
        req_valid = 1; req_write = 1; req_index = IW'(idx); req_code = code; req_wdata = p;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        @(negedge clk);
        chk(wr_ops - w0 == exp_wr, rq, "write op count", LBITS'(wr_ops - w0), LBITS'(exp_wr));
        if (exp_wr > 0)
            chk(last_wmask == exp_mask, rq, "write lanes", LBITS'(last_wmask), LBITS'(exp_mask));
        chk(req_ready == 1'b1, "R7", "ready after write", LBITS'(req_ready), 1);
    endtask

    task automatic do_read(input int idx, input logic [3:0] exp_code, input logic [LBITS-1:0] exp_data,
                           input int exp_lat, input int exp_rd, input int exp_wr,
                           input logic [LB-1:0] exp_mask, input string rq);
        int r0, w0, lat;
        r0 = rd_ops; w0 = wr_ops;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_index = IW'(idx);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            if (req_ready) chk(0, "R7", "ready while read busy", 1, 0);
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R7", "read latency", LBITS'(lat), LBITS'(exp_lat));
        chk(rsp_data == exp_data, rq, "read data", rsp_data, exp_data);
        chk(rsp_code == exp_code, rq, "read code", LBITS'(rsp_code), LBITS'(exp_code));
        @(negedge clk);
        chk(rd_ops - r0 == exp_rd, rq, "array reads", LBITS'(rd_ops - r0), LBITS'(exp_rd));
        chk(wr_ops - w0 == exp_wr, rq, "restore writes", LBITS'(wr_ops - w0), LBITS'(exp_wr));
        if (exp_rd > 0)
            chk(last_rmask == exp_mask, rq, "read lanes", LBITS'(last_rmask), LBITS'(exp_mask));
        if (exp_wr > 0)
            chk(last_wmask == exp_mask, "R5", "restore lanes", LBITS'(last_wmask), LBITS'(exp_mask));
        if (exp_wr > 0) exp_rest++; else exp_skip++;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", LBITS'(req_ready), 1);
        chk(cnt_skip == 0 && cnt_restore == 0, "R1", "counters after reset",
            LBITS'({cnt_skip, cnt_restore}), 0);
        do_read(3, 4'b0000, '0, 1, 0, 0, '0, "R1");
    endtask

    task automatic t_zero();
        do_write(2, 4'b0000, pattern(5), 0, '0, "R2");
        do_read(2, 4'b0000, '0, 1, 0, 0, '0, "R2");
    endtask

    task automatic t_dual();
        logic [3:0] dc [4] = '{4'b0011, 4'b0110, 4'b1101, 4'b0111};
        logic [3:0] sc [4] = '{4'b0001, 4'b0010, 4'b1100, 4'b0101};
        for (int k = 0; k < 4; k++) begin
            int n;
            logic [LBITS-1:0] p;
            n = bsize(dc[k]);
            p = pattern(10 + k);
            do_write(4 + k, dc[k], p, 1, lanes(n, 0) | lanes(n, 32), "R3");
            do_read(4 + k, dc[k], trunc(p, n), 2, 1, 0, lanes(n, 32), "R4");
            do_read(4 + k, sc[k], trunc(p, n), 2, 1, 1, lanes(n, 0), "R5");
            do_read(4 + k, sc[k], trunc(p, n), 2, 1, 1, lanes(n, 0), "R5");
        end
    endtask

    task automatic t_single();
        do_write(8, 4'b1111, pattern(20), 1, '1, "R5");
        do_read(8, 4'b1111, pattern(20), 2, 1, 1, '1, "R5");
        do_read(8, 4'b1111, pattern(20), 2, 1, 1, '1, "R5");
        do_write(9, 4'b0100, pattern(21), 1, lanes(34, 0), "R9");
        do_read(9, 4'b0100, trunc(pattern(21), 34), 2, 1, 1, lanes(34, 0), "R9");
        do_write(10, 4'b1000, pattern(22), 1, lanes(36, 0), "R9");
        do_read(10, 4'b1000, trunc(pattern(22), 36), 2, 1, 1, lanes(36, 0), "R9");
        do_write(11, 4'b1010, pattern(23), 1, '1, "R5");
        do_read(11, 4'b1010, pattern(23), 2, 1, 1, '1, "R5");
    endtask

    task automatic t_rewrite();
        do_write(4, 4'b0110, pattern(30), 1, lanes(15, 0) | lanes(15, 32), "R6");
        do_read(4, 4'b0110, trunc(pattern(30), 15), 2, 1, 0, lanes(15, 32), "R6");
        do_write(8, 4'b0000, pattern(31), 0, '0, "R6");
        do_read(8, 4'b0000, '0, 1, 0, 0, '0, "R6");
    endtask

    initial begin
        for (int i = 0; i < NB; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_dual();
        t_single();
        t_rewrite();
        @(negedge clk);
        chk(int'(cnt_skip) == exp_skip, "R8", "skip counter", LBITS'(cnt_skip), LBITS'(exp_skip));
        chk(int'(cnt_restore) == exp_rest, "R8", "restore counter", LBITS'(cnt_restore), LBITS'(exp_rest));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule